// File: doc/BRIEF.md
# Paged Program Memory Address Mapper

This block sits between a CPU with a 16-bit logical address and a flash array of eight 16 KB pages (128 KB, 17-bit physical address). The logical space splits into four 16 KB quarters chosen by the top two address bits. Three quarters always reach the same physical page: the bottom quarter reaches page 0, the second quarter reaches page 1 and the top quarter reaches page 3. The third quarter, logical 0x8000 to 0xBFFF, is a paging window. It shows whichever page the writable page register selects.

The fixed quarters never look at the page register. Code placed in them, such as an interrupt handler, therefore runs the same way whatever page is selected and does not need to save the register. Because the window can select any page, a fixed page can be seen at two logical addresses at once. Flash of page 0 that is covered by RAM and peripheral registers can be reached only through the window with the register set to 0.

An input from the neighbouring RAM and register decoder reports that it has claimed the current address. For an access to a fixed quarter, this input removes the flash select. An access through the window always selects flash.

Top module: `pmap_top`

## Requirements
- R1: After reset the page register holds 2, and the read port returns 8'h02.
- R2: A cycle with the write strobe high loads the low 3 bits of the write data into the page register at that clock edge. The 8-bit read port returns the register in bits [2:0] and zero in bits [7:3].
- R3: A logical address with bits [15:14] equal to 2'b10 (0x8000–0xBFFF) is a window access. windowHit is 1 and physAddr is {page register, logAddr[13:0]}.
- R4: Outside the window, physAddr is {fixed page, logAddr[13:0]} and windowHit is 0. The fixed page is 0 for 2'b00, 1 for 2'b01 and 3 for 2'b11, whatever the page register holds.
- R5: With the page register at 1, logical 0x4000 and 0x8000 give the same physAddr. With the register at 3, logical 0xC000 and 0x8000 give the same physAddr.
- R6: When ramRegClaim is high during a fixed-quarter access, flashSel is 0. During a window access flashSel is 1 whatever the value of ramRegClaim.
- R7: With the page register at 0, a window access reaches page 0 flash (physAddr below 0x04000) with flashSel 1, even when the same offset at its fixed logical address is claimed.
- R8: While the write strobe is low, the page register keeps its value whatever the write data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pageWrEn | input | 1 | Write strobe for the page register |
| pageWrData | input | 8 | Write data for the page register; bits [2:0] are used |
| pageRdData | output | 8 | Current page register, zero-extended |
| logAddr | input | 16 | CPU logical address |
| ramRegClaim | input | 1 | RAM or register decoder has claimed the address |
| physAddr | output | 17 | Physical flash address |
| windowHit | output | 1 | The access went through the paging window |
| flashSel | output | 1 | Flash select for the current access |

## Verification
The bench writes each page value and probes addresses at the edges of every quarter (0x7FFF, 0x8000, 0xBFFF, 0xC000). A decoder with a wrong boundary would place those addresses in the wrong page. Paired probes check the two aliases. A mapper that let the register leak into the fixed quarters, or that ignored it in the window, would give different physical addresses for the two halves of a pair. The bench also sends a claim into both a fixed quarter and the window. A design that honoured the claim in the window would lose hidden page 0, and one that ignored the claim in a fixed quarter would drive flash and RAM together. Writes with high data bits and idle cycles with junk data expose a register that takes too many bits or loads without the strobe.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
  localparam int LOG_W    = 16;
  localparam int PAGE_W   = 3;
  localparam int OFS_W    = 14;
  localparam int REGION_W = LOG_W - OFS_W;
  localparam int PHYS_W   = PAGE_W + OFS_W;
  localparam int REG_W    = 8;
  localparam int N_REGION = 1 << REGION_W;

  typedef struct packed {
    logic              loadPage;
    logic              useWindow;
    logic [PAGE_W-1:0] fixedPage;
    logic              blockFlash;
  } mapStrobes_t;
endpackage

// File: rtl/pmap_ctrl.sv
module pmap_ctrl
  import pmap_pkg::*;
#(
  parameter int WIN_REGION = 2,
  parameter int PAGE_Q0    = 0,
  parameter int PAGE_Q1    = 1,
  parameter int PAGE_Q3    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pageWrEn,
  input  logic [REGION_W-1:0] region,
  input  logic                ramRegClaim,
  output mapStrobes_t         strobes
);
  logic [PAGE_W-1:0] fixedTable [N_REGION];

  for (genvar r = 0; r < N_REGION; r++) begin : g_region
    localparam int PG = (r == 0) ? PAGE_Q0 :
                        (r == 1) ? PAGE_Q1 :
                        (r == 3) ? PAGE_Q3 : 0;
    assign fixedTable[r] = PAGE_W'(PG);
  end

  logic inWindow;
  assign inWindow = (region == REGION_W'(WIN_REGION));

  always_comb begin
    strobes.loadPage   = pageWrEn;
    strobes.useWindow  = inWindow;
    strobes.fixedPage  = fixedTable[region];
    strobes.blockFlash = ramRegClaim && !inWindow;
  end

  // R6: the claim input never reaches the strobe struct for a window access
  assert_window_unblocked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (region == REGION_W'(WIN_REGION)) |-> !strobes.blockFlash);
endmodule

// File: rtl/pmap_datapath.sv
module pmap_datapath
  import pmap_pkg::*;
#(
  parameter int RESET_PAGE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  mapStrobes_t       strobes,
  input  logic [REG_W-1:0]  wrData,
  input  logic [OFS_W-1:0]  offset,
  output logic [PHYS_W-1:0] physAddr,
  output logic [REG_W-1:0]  pageRdData,
  output logic              windowHit,
  output logic              flashSel
);
  logic [PAGE_W-1:0] pageReg;
  logic [PAGE_W-1:0] selPage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pageReg <= PAGE_W'(RESET_PAGE);
    else if (strobes.loadPage) pageReg <= wrData[PAGE_W-1:0];
  end

  always_comb begin
    selPage    = strobes.useWindow ? pageReg : strobes.fixedPage;
    physAddr   = {selPage, offset};
    pageRdData = {{(REG_W-PAGE_W){1'b0}}, pageReg};
    windowHit  = strobes.useWindow;
    flashSel   = !strobes.blockFlash;
  end

  assert_reset_value_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> pageReg == PAGE_W'(RESET_PAGE));

  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadPage |=> pageReg == $past(wrData[PAGE_W-1:0]));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadPage |=> $stable(pageReg));
endmodule

// File: rtl/pmap_top.sv
module pmap_top
  import pmap_pkg::*;
#(
  parameter int RESET_PAGE = 2,
  parameter int WIN_REGION = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pageWrEn,
  input  logic [REG_W-1:0]  pageWrData,
  output logic [REG_W-1:0]  pageRdData,
  input  logic [LOG_W-1:0]  logAddr,
  input  logic              ramRegClaim,
  output logic [PHYS_W-1:0] physAddr,
  output logic              windowHit,
  output logic              flashSel
);
  mapStrobes_t strobes;

  pmap_ctrl #(.WIN_REGION(WIN_REGION)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pageWrEn   (pageWrEn),
    .region     (logAddr[LOG_W-1:OFS_W]),
    .ramRegClaim(ramRegClaim),
    .strobes    (strobes)
  );

  pmap_datapath #(.RESET_PAGE(RESET_PAGE)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (pageWrData),
    .offset    (logAddr[OFS_W-1:0]),
    .physAddr  (physAddr),
    .pageRdData(pageRdData),
    .windowHit (windowHit),
    .flashSel  (flashSel)
  );

  assert_window_map_R3: assert property (@(posedge clk) disable iff (!rstN)
    windowHit |-> (physAddr[PHYS_W-1:OFS_W] == pageRdData[PAGE_W-1:0]) &&
                  (physAddr[OFS_W-1:0] == logAddr[OFS_W-1:0]));

  assert_fixed_map_R4: assert property (@(posedge clk) disable iff (!rstN)
    !windowHit |-> physAddr[PHYS_W-1:OFS_W] ==
      (logAddr[LOG_W-1] ? PAGE_W'(3) : PAGE_W'(logAddr[OFS_W])));

  assert_claim_fixed_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ramRegClaim && !windowHit) |-> !flashSel);

  assert_window_selects_R6: assert property (@(posedge clk) disable iff (!rstN)
    windowHit |-> flashSel);
endmodule

// File: tb/pmap_top_test.sv
module pmap_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pageWrEn = 1'b0;
  logic [7:0]  pageWrData = 8'h00;
  logic [7:0]  pageRdData;
  logic [15:0] logAddr = 16'h0000;
  logic        ramRegClaim = 1'b0;
  logic [16:0] physAddr;
  logic        windowHit;
  logic        flashSel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pmap_top uut (
    .clk(clk), .rstN(rstN), .pageWrEn(pageWrEn), .pageWrData(pageWrData),
    .pageRdData(pageRdData), .logAddr(logAddr), .ramRegClaim(ramRegClaim),
    .physAddr(physAddr), .windowHit(windowHit), .flashSel(flashSel)
  );

  // {page[2:0], addr[15:0], claim, phys[16:0], win, sel}
  localparam int NV = 14;
  localparam logic [38:0] VEC [NV] = '{
    {3'd2, 16'h0123, 1'b0, 17'h00123, 1'b0, 1'b1},  // R4
    {3'd2, 16'h4567, 1'b0, 17'h04567, 1'b0, 1'b1},  // R4
    {3'd2, 16'h8ABC, 1'b0, 17'h08ABC, 1'b1, 1'b1},  // R3
    {3'd2, 16'hC001, 1'b0, 17'h0C001, 1'b0, 1'b1},  // R4
    {3'd5, 16'hBFFF, 1'b0, 17'h17FFF, 1'b1, 1'b1},  // R3 top edge
    {3'd5, 16'hFFFF, 1'b0, 17'h0FFFF, 1'b0, 1'b1},  // R4
    {3'd7, 16'h8000, 1'b1, 17'h1C000, 1'b1, 1'b1},  // R6 claim ignored
    {3'd1, 16'h4000, 1'b0, 17'h04000, 1'b0, 1'b1},  // R5
    {3'd1, 16'h8000, 1'b0, 17'h04000, 1'b1, 1'b1},  // R5
    {3'd3, 16'hC000, 1'b0, 17'h0C000, 1'b0, 1'b1},  // R5
    {3'd3, 16'h8000, 1'b0, 17'h0C000, 1'b1, 1'b1},  // R5
    {3'd0, 16'h8010, 1'b1, 17'h00010, 1'b1, 1'b1},  // R7
    {3'd0, 16'h0010, 1'b1, 17'h00010, 1'b0, 1'b0},  // R6/R7
    {3'd6, 16'h7FFF, 1'b1, 17'h07FFF, 1'b0, 1'b0}   // R6 edge
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writePage(input logic [7:0] d);
    @(negedge clk);
    pageWrEn = 1'b1;
    pageWrData = d;
    @(negedge clk);
    pageWrEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset page", {24'd0, pageRdData}, 32'h02);

    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      v = VEC[i];
      writePage({5'd0, v[38:36]});
      logAddr = v[35:20];
      ramRegClaim = v[19];
      #1;
      check("R2 readback", {24'd0, pageRdData}, {29'd0, v[38:36]});
      check("R3/R4/R5/R7 physAddr", {15'd0, physAddr}, {15'd0, v[18:2]});
      check("R3/R4 windowHit", {31'd0, windowHit}, {31'd0, v[1]});
      check("R6 flashSel", {31'd0, flashSel}, {31'd0, v[0]});
    end
    ramRegClaim = 1'b0;

    // R2: upper write bits dropped, read upper bits zero
    writePage(8'hFD);
    #1 check("R2 low bits only", {24'd0, pageRdData}, 32'h05);
    logAddr = 16'h9234;
    #1 check("R2 window uses written page", {15'd0, physAddr}, 32'h15234);

    // R8: junk data without strobe is ignored
    @(negedge clk);
    pageWrData = 8'hFA;
    repeat (3) @(negedge clk);
    #1 check("R8 hold without strobe", {24'd0, pageRdData}, 32'h05);
    #1 check("R8 window unchanged", {15'd0, physAddr}, 32'h15234);

    // R4: fixed quarters ignore every page value
    for (int p = 0; p < 8; p++) begin
      writePage(p[7:0]);
      logAddr = 16'hC7AB;
      #1 check("R4 fixed top quarter", {15'd0, physAddr}, 32'h0C7AB);
      logAddr = 16'h3FFF;
      #1 check("R4 fixed bottom quarter", {15'd0, physAddr}, 32'h03FFF);
    end

    // R1: reset mid-run returns page 2
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    logAddr = 16'h8001;
    #1 check("R1 reset after write", {24'd0, pageRdData}, 32'h02);
    #1 check("R1 window after reset", {15'd0, physAddr}, 32'h08001);

    repeat (2) @(negedge clk);
    finishRun();
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end
endmodule